// File: doc/BRIEF.md
# Oversampled Serial Receive Engine with Flow-Control Request

This block turns an asynchronous serial line into bytes. It watches either an external receive pin or, with loopback selected, the local transmit output. The chosen line passes through a two-stage synchronizer. A falling edge starts a character. An oversample tick paces the sampling, at 8 or 16 ticks per bit. The engine confirms the start bit at its middle, samples eight data bits least significant first, and checks the stop bit. It then offers the byte, together with a framing-error flag, on a valid/ready stream toward a receive FIFO.

The stream output holds one entry. While `out_valid` is 1 and `out_ready` is 0, the data and flag stay frozen. A new character that completes during that time is discarded, and the older entry is kept. A completed character is accepted into the entry when the entry is empty, or when it is being consumed in that same cycle.

The FIFO storage lies outside this block, and only its fill count comes in. A separate output requests more data from the far end while the fill is below a programmable watermark. It drops when the watermark is reached, and it stays low whenever the request function is turned off.

Top module: `serial_rx_engine`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and `rts` is 0.
- R2: A new character is started only when `en_all` and `rx_en` are both 1. A complete frame sent while either is 0 produces no output.
- R3: If `rx_en` or `en_all` is cleared after a character has started, that character is still received and delivered in full.
- R4: With `loop_en`=1 the engine decodes `tx_loop` and ignores `rx_pin`. With `loop_en`=0 it decodes `rx_pin` and ignores `tx_loop`.
- R5: `fast_mode`=1 selects 8 oversample ticks per bit and `fast_mode`=0 selects 16. The mode is captured when the start edge is seen.
- R6: A start is confirmed only if the line is still low at the middle of the start bit. A shorter low pulse returns the engine to idle and produces no output.
- R7: Data bits are taken at the middle of each bit, least significant bit first. The eighth data bit is `out_data[7]`.
- R8: `out_ferr` is 1 when the stop bit is sampled low and 0 when it is sampled high. The byte is delivered in both cases.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_ferr` stay unchanged. A character that completes during that time is dropped.
- R10: With `rts_en`=1, one cycle after the inputs settle, `rts` is 1 when `fifo_fill` < `watermark` and 0 when `fifo_fill` >= `watermark`.
- R11: With `rts_en`=0, `rts` is 0 one cycle later, whatever the fill and watermark are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample tick, one-cycle pulse |
| rx_pin | input | 1 | External serial receive line, idle high |
| tx_loop | input | 1 | Local transmit output used when loopback is on |
| en_all | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| loop_en | input | 1 | Loopback select |
| fast_mode | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| rts_en | input | 1 | Flow-control request enable |
| watermark | input | FILL_W | Fill level at which `rts` drops |
| fifo_fill | input | FILL_W | Current receive FIFO fill count |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Received byte |
| out_ferr | output | 1 | Stop bit was sampled low |
| rts | output | 1 | Request-to-send, active high |

## Verification
The hardest case to reach from the ports is a disable that lands in the middle of a character. The bench builds that frame bit by bit and clears `rx_en` after the third data bit. It checks that the byte still arrives, then that the next full frame is ignored. The dropped-character rule under back-pressure also needs set-up: two frames are sent back to back with `out_ready` held low, and the first byte must survive. A short low glitch checks that the start is rejected. Random bytes, stop levels, sampling modes and line selections run on a fixed seed.

// File: rtl/serx_pkg.sv
package serx_pkg;
  parameter int unsigned CHAR_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              ferr;
  } rx_word_t;
endpackage

// File: rtl/serx_sync.sv
module serx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= INIT;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= INIT;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serx_bit_engine.sv
module serx_bit_engine
  import serx_pkg::*;
#(
  parameter int unsigned OSR_FAST = 8,
  parameter int unsigned OSR_SLOW = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line,
  input  logic     tick,
  input  logic     go,
  input  logic     fast,
  output logic     push_valid,
  output rx_word_t push_word
);
  localparam int unsigned CNT_W = $clog2(OSR_SLOW);
  localparam int unsigned BIT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(OSR_FAST - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(OSR_SLOW - 1);
  localparam logic [CNT_W-1:0] HALF_F = CNT_W'(OSR_FAST / 2 - 1);
  localparam logic [CNT_W-1:0] HALF_S = CNT_W'(OSR_SLOW / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CHAR_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [CHAR_W-1:0] shreg;
  logic              fast_q;
  logic              line_prev;
  logic [CNT_W-1:0]  cnt_last;
  logic [CNT_W-1:0]  cnt_half;
  logic              fall;

  assign cnt_last = fast_q ? LAST_F : LAST_S;
  assign cnt_half = fast_q ? HALF_F : HALF_S;
  assign fall     = line_prev & ~line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_prev <= 1'b1;
    else        line_prev <= line;
  end

  // Enable is looked at only in idle, so a started character always finishes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      fast_q     <= 1'b0;
      push_valid <= 1'b0;
      push_word  <= '0;
    end else begin
      push_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go && fall) begin
            state  <= ST_START;
            cnt    <= '0;
            fast_q <= fast;
          end
        end
        ST_START: begin
          if (tick) begin
            if (cnt == cnt_half) begin
              cnt     <= '0;
              bit_idx <= '0;
              state   <= line ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (cnt == cnt_last) begin
              cnt   <= '0;
              shreg <= {line, shreg[CHAR_W-1:1]};
              if (bit_idx == BIT_LAST) state <= ST_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (cnt == cnt_last) begin
              cnt            <= '0;
              push_valid     <= 1'b1;
              push_word.data <= shreg;
              push_word.ferr <= ~line;
              state          <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serx_out_stage.sv
module serx_out_stage
  import serx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  rx_word_t          push_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_ferr
);
  logic can_take;
  assign can_take = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ferr  <= 1'b0;
    end else if (push_valid && can_take) begin
      out_valid <= 1'b1;
      out_data  <= push_word.data;
      out_ferr  <= push_word.ferr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serx_rts.sv
module serx_rts #(
  parameter int unsigned FILL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rts_en,
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] level,
  output logic              rts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts <= 1'b0;
    else        rts <= rts_en && (fill < level);
  end
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import serx_pkg::*;
#(
  parameter int unsigned OSR_FAST    = 8,
  parameter int unsigned OSR_SLOW    = 16,
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FILL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_pin,
  input  logic              tx_loop,
  input  logic              en_all,
  input  logic              rx_en,
  input  logic              loop_en,
  input  logic              fast_mode,
  input  logic              rts_en,
  input  logic [FILL_W-1:0] watermark,
  input  logic [FILL_W-1:0] fifo_fill,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_ferr,
  output logic              rts
);
  logic     raw_line;
  logic     line_s;
  logic     push_valid;
  rx_word_t push_word;

  assign raw_line = loop_en ? tx_loop : rx_pin;

  serx_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_line), .q(line_s)
  );

  serx_bit_engine #(.OSR_FAST(OSR_FAST), .OSR_SLOW(OSR_SLOW)) u_engine (
    .clk(clk), .rst_n(rst_n), .line(line_s), .tick(os_tick),
    .go(en_all & rx_en), .fast(fast_mode),
    .push_valid(push_valid), .push_word(push_word)
  );

  serx_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ferr(out_ferr)
  );

  serx_rts #(.FILL_W(FILL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .rts_en(rts_en), .fill(fifo_fill),
    .level(watermark), .rts(rts)
  );
endmodule

// File: rtl/serx_checker.sv
module serx_checker #(
  parameter int unsigned FILL_W = 5,
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rts_en,
  input logic [FILL_W-1:0] watermark,
  input logic [FILL_W-1:0] fifo_fill,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CHAR_W-1:0] out_data,
  input logic              out_ferr,
  input logic              rts
);
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ferr));

  p_rts_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_en |=> !rts);

  p_rts_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rts_en && (fifo_fill >= watermark) |=> !rts);

  p_rts_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rts_en && (fifo_fill < watermark) |=> rts);
endmodule

bind serial_rx_engine serx_checker #(.FILL_W(FILL_W), .CHAR_W(serx_pkg::CHAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rts_en(rts_en), .watermark(watermark),
  .fifo_fill(fifo_fill), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_ferr(out_ferr), .rts(rts)
);

// File: tb/serial_rx_engine_test.sv
module serial_rx_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int FILL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b1;
  logic rx_pin = 1'b1, tx_loop = 1'b1;
  logic en_all = 1'b0, rx_en = 1'b0, loop_en = 1'b0, fast_mode = 1'b0;
  logic rts_en = 1'b0;
  logic [FILL_W-1:0] watermark = '0, fifo_fill = '0;
  logic out_valid, out_ready = 1'b0, out_ferr, rts;
  logic [7:0] out_data;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  serial_rx_engine uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
    .tx_loop(tx_loop), .en_all(en_all), .rx_en(rx_en), .loop_en(loop_en),
    .fast_mode(fast_mode), .rts_en(rts_en), .watermark(watermark),
    .fifo_fill(fifo_fill), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ferr(out_ferr), .rts(rts)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_rts(input bit en, input int fill, input int wm);
    return en && (fill < wm);
  endfunction

  function automatic int bit_len(input bit fast);
    return fast ? 8 : 16;
  endfunction

  // The selected line carries v; the other line carries its inverse as noise.
  task automatic drive_bit(input logic v, input int n);
    if (loop_en) begin tx_loop = v; rx_pin = ~v; end
    else         begin rx_pin = v;  tx_loop = ~v; end
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_idle();
    rx_pin = 1'b1; tx_loop = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop, input int n);
    drive_bit(1'b0, n);
    for (int i = 0; i < 8; i++) drive_bit(d[i], n);
    drive_bit(stop, n);
    drive_bit(1'b1, n);
  endtask

  task automatic expect_byte(input string req, input logic [7:0] d, input logic f);
    chk(req, out_valid, 1'b1);
    chk(req, out_data, d);
    chk(req, out_ferr, f);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(req, out_valid, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rts_en = 1'b1; watermark = 5'd4; fifo_fill = 5'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", out_valid, 1'b0);
    chk("R1 reset rts", rts, 1'b0);
    rst_n = 1'b1;
    rts_en = 1'b0;
    @(negedge clk);
    chk("R1 after reset valid", out_valid, 1'b0);

    // R10 / R11 flow-control request
    for (int i = 0; i < 24; i++) begin
      logic e; int f, w;
      e = ($urandom % 3) != 0;
      w = $urandom % 17;
      case (i % 4)
        0: f = w;
        1: f = (w > 0) ? w - 1 : 0;
        default: f = $urandom % 17;
      endcase
      rts_en = e; watermark = FILL_W'(w); fifo_fill = FILL_W'(f);
      @(negedge clk);
      chk(e ? "R10 rts level" : "R11 rts disabled", rts, exp_rts(e, f, w));
    end
    rts_en = 1'b0;

    en_all = 1'b1; rx_en = 1'b1;
    // R7 / R8 basic frames in 16x mode on the external pin
    settle_idle();
    send_frame(8'hA5, 1'b1, 16);
    expect_byte("R7 byte A5", 8'hA5, 1'b0);
    settle_idle();
    send_frame(8'h3C, 1'b0, 16);
    expect_byte("R8 framing error", 8'h3C, 1'b1);

    // R5 fast mode, R4 loopback
    fast_mode = 1'b1; loop_en = 1'b1;
    settle_idle();
    send_frame(8'h81, 1'b1, 8);
    expect_byte("R4 R5 loopback fast", 8'h81, 1'b0);

    // R6 short start glitch
    fast_mode = 1'b0; loop_en = 1'b0;
    settle_idle();
    rx_pin = 1'b0; repeat (2) @(negedge clk);
    rx_pin = 1'b1; repeat (40) @(negedge clk);
    chk("R6 glitch rejected", out_valid, 1'b0);

    // R2 disabled reception
    en_all = 1'b0;
    settle_idle();
    send_frame(8'h5A, 1'b1, 16);
    chk("R2 en_all off", out_valid, 1'b0);
    en_all = 1'b1; rx_en = 1'b0;
    settle_idle();
    send_frame(8'h5A, 1'b1, 16);
    chk("R2 rx_en off", out_valid, 1'b0);
    rx_en = 1'b1;

    // R3 disable in the middle of a character
    settle_idle();
    begin
      logic [7:0] d;
      d = 8'hC7;
      drive_bit(1'b0, 16);
      for (int i = 0; i < 8; i++) begin
        if (i == 3) rx_en = 1'b0;
        drive_bit(d[i], 16);
      end
      drive_bit(1'b1, 16);
      drive_bit(1'b1, 16);
      expect_byte("R3 completes after disable", d, 1'b0);
    end
    settle_idle();
    send_frame(8'h11, 1'b1, 16);
    chk("R3 stopped after character", out_valid, 1'b0);
    rx_en = 1'b1;

    // R9 back-pressure: second character dropped
    settle_idle();
    send_frame(8'h6E, 1'b1, 16);
    send_frame(8'h19, 1'b0, 16);
    expect_byte("R9 first kept, second dropped", 8'h6E, 1'b0);

    // Random frames across modes and line selections
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d; logic s;
      fast_mode = $urandom % 2;
      loop_en   = $urandom % 2;
      d = $urandom; s = ($urandom % 4) != 0;
      settle_idle();
      send_frame(d, s, bit_len(fast_mode));
      expect_byte(loop_en ? "R4 R7 R8 random loop" : "R5 R7 R8 random pin", d, ~s);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule